// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a four-bank SDRAM's contents alive by issuing periodic auto-refresh commands. A free-running interval timer adds one owed refresh each time it expires. The block then asks the main memory controller for the command bus with a request line. When the controller answers with a grant, the block drives the refresh command itself. If any bank still has an open row, the block first drives a precharge-all command. It then waits for the controller to report that every bank is idle, and only then drives the refresh.

Refreshes that come due while the controller keeps traffic flowing are not lost. They accumulate in a saturating backlog counter, and once the grant arrives they are issued back to back at row-cycle spacing. After each refresh a hold output tells the controller to keep the bus quiet for the row cycle time. The default interval of 1562 clocks matches a 100 MHz clock and 4096 refreshes per 64 ms. The default row cycle time is 7 clocks.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is held, `rfsh_req` and `rfsh_hold` are low and the command bus is deselected: `cmd_cs_n`, `cmd_ras_n`, `cmd_cas_n` and `cmd_we_n` are all 1 and `cmd_a10` is 0.
- R2: After reset is released, `rfsh_req` stays low for INTERVAL-1 clock edges and is high after edge INTERVAL. Each further INTERVAL clocks add one owed refresh.
- R3: The owed count saturates at MAX_OWED. Intervals that expire while the count is full are dropped, so a long wait without a grant yields exactly MAX_OWED refreshes once the grant arrives.
- R4: While `rfsh_gnt` is low the block drives no command (`cmd_cs_n` stays 1), and `rfsh_req` stays high as long as refreshes are owed.
- R5: The refresh command is encoded as cs_n=0, ras_n=0, cas_n=0, we_n=1. If the grant is sampled high together with `banks_idle`, the refresh appears in the cycle right after that edge.
- R6: The precharge-all command is encoded as cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. If the grant is sampled with `banks_idle` low, precharge-all appears in the cycle after that edge. A waiting state begins one cycle later. The refresh appears in the cycle after `banks_idle` is sampled high in the waiting state.
- R7: `rfsh_hold` is high for exactly TRC_CLKS cycles, starting with the cycle that carries the refresh command.
- R8: With several refreshes owed, a held grant and idle banks, successive refresh commands are exactly TRC_CLKS cycles apart.
- R9: When the last owed refresh completes, `rfsh_req` falls in the same cycle that `rfsh_hold` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when every bank is precharged |
| rfsh_gnt | input | 1 | Controller hands the command bus to the scheduler |
| rfsh_req | output | 1 | Scheduler wants the command bus |
| rfsh_hold | output | 1 | Controller must issue no command this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10, selects all banks for precharge |

## Verification
The grant path is exercised with four bank-busy durations after the grant: zero, one, two and five cycles. The zero case separates the direct refresh from the precharge-first path. The one- and two-cycle cases show that the waiting state cannot be skipped. The five-cycle case shows that the refresh tracks the moment the banks become idle. A separate run withholds the grant for six intervals. It shows that the bus stays silent, that the backlog stops at its cap rather than wrapping or growing, and that the drained refreshes come at exact row-cycle spacing.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int INTERVAL = 1562,
  parameter int TRC_CLKS = 7,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic rfsh_gnt,
  output logic rfsh_req,
  output logic rfsh_hold,
  output logic cmd_cs_n,
  output logic cmd_ras_n,
  output logic cmd_cas_n,
  output logic cmd_we_n,
  output logic cmd_a10
);

  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam int RW = (TRC_CLKS > 2) ? $clog2(TRC_CLKS - 1) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_PWAIT, S_REF, S_RC} st_t;

  st_t           state, state_nxt;
  logic [TW-1:0] tmr;
  logic [OW-1:0] owed, owed_less, owed_nxt;
  logic [RW-1:0] rc_cnt;
  logic          tick;
  st_t           launch;

  assign tick      = (tmr == '0);
  assign owed_less = owed - OW'(state == S_REF);
  assign owed_nxt  = (tick && owed_less != OW'(MAX_OWED)) ? owed_less + 1'b1 : owed_less;
  assign launch    = banks_idle ? S_REF : S_PRE;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= TW'(INTERVAL - 1);
    else if (tick) tmr <= TW'(INTERVAL - 1);
    else tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else owed <= owed_nxt;
  end

  always_comb begin
    state_nxt = state;
    case (state)
      S_IDLE:  if (owed != '0 && rfsh_gnt) state_nxt = launch;
      S_PRE:   state_nxt = S_PWAIT;
      S_PWAIT: if (banks_idle) state_nxt = S_REF;
      S_REF:   state_nxt = S_RC;
      S_RC:    if (rc_cnt == '0)
                 state_nxt = (owed != '0 && rfsh_gnt) ? launch : S_IDLE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rc_cnt <= '0;
    end else begin
      state <= state_nxt;
      if (state == S_REF) rc_cnt <= RW'(TRC_CLKS - 2);
      else if (state == S_RC && rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;
    end
  end

  assign rfsh_req  = (owed != '0) || (state != S_IDLE);
  assign rfsh_hold = (state == S_REF) || (state == S_RC);
  assign cmd_cs_n  = !((state == S_REF) || (state == S_PRE));
  assign cmd_ras_n = !((state == S_REF) || (state == S_PRE));
  assign cmd_cas_n = (state != S_REF);
  assign cmd_we_n  = (state != S_PRE);
  assign cmd_a10   = (state == S_PRE);

  // R5
  ref_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_REF) |-> $past(banks_idle));

  // R3
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));

  // R7
  ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_cs_n && !cmd_cas_n) |=> (rfsh_hold && cmd_cs_n));

  // R6
  wait_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWAIT) |-> $past(state == S_PRE || state == S_PWAIT));

  // R4
  pre_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |-> $past(rfsh_gnt));

endmodule

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb_top;
  localparam int INTERVAL = 200;
  localparam int TRC      = 7;
  localparam int MAXO     = 4;
  localparam int NV       = 4;
  localparam int VEC_BUSY[NV] = '{0, 1, 2, 5};
  localparam int VEC_LAT [NV] = '{1, 3, 3, 6};

  logic clk = 0, rst_n = 0, banks_idle = 1, rfsh_gnt = 0;
  logic rfsh_req, rfsh_hold, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_refresh_sched #(.INTERVAL(INTERVAL), .TRC_CLKS(TRC), .MAX_OWED(MAXO)) dut_i (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .rfsh_gnt(rfsh_gnt),
    .rfsh_req(rfsh_req), .rfsh_hold(rfsh_hold), .cmd_cs_n(cmd_cs_n),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_a10(cmd_a10));

  function automatic bit is_ref();
    return !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && cmd_we_n;
  endfunction
  function automatic bit is_pre();
    return !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n && cmd_a10;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rfsh_gnt = 0; banks_idle = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(!rfsh_req && !rfsh_hold, "R1 req/hold", {rfsh_req, rfsh_hold}, 0);
    check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10} == 5'b11110, "R1 bus",
          {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10}, 5'b11110);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic first_req();
    int early = 0;
    for (int n = 1; n < INTERVAL; n++) begin
      @(posedge clk); #1;
      if (rfsh_req) early++;
    end
    // R2
    check(early == 0, "R2 early req", early, 0);
    @(posedge clk); #1;
    check(rfsh_req, "R2 req after interval", rfsh_req, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      int d, lat, pre_at, h;
      d = VEC_BUSY[v]; lat = 0; pre_at = 0;
      do_reset();
      first_req();
      @(negedge clk);
      rfsh_gnt = 1; banks_idle = (d == 0);
      for (int k = 1; k <= 40; k++) begin
        @(posedge clk); #1;
        if (is_pre() && pre_at == 0) pre_at = k;
        if (is_ref()) begin lat = k; break; end
        if (k == d) banks_idle = 1;
      end
      if (d == 0) begin
        // R5
        check(lat == VEC_LAT[v], "R5 ref latency", lat, VEC_LAT[v]);
        check(pre_at == 0, "R5 no precharge", pre_at, 0);
      end else begin
        // R6
        check(lat == VEC_LAT[v], "R6 ref latency", lat, VEC_LAT[v]);
        check(pre_at == 1, "R6 precharge cycle", pre_at, 1);
      end
      h = rfsh_hold ? 1 : 0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk); #1;
        if (!rfsh_hold) break;
        h++;
      end
      // R7
      check(h == TRC, "R7 hold length", h, TRC);
      // R9
      check(!rfsh_req, "R9 req with hold", rfsh_req, 0);
      @(negedge clk) rfsh_gnt = 0;
    end

    begin
      int bad, refs, last, spc_bad;
      bad = 0; refs = 0; last = 0; spc_bad = 0;
      do_reset();
      for (int n = 0; n < 6 * INTERVAL + 5; n++) begin
        @(posedge clk); #1;
        if (!cmd_cs_n) bad++;
      end
      // R4
      check(bad == 0, "R4 bus silent", bad, 0);
      check(rfsh_req, "R4 req held", rfsh_req, 1);
      @(negedge clk) rfsh_gnt = 1;
      for (int k = 1; k <= 4 * TRC + 10; k++) begin
        @(posedge clk); #1;
        if (is_ref()) begin
          if (refs > 0 && k - last != TRC) spc_bad++;
          last = k; refs++;
        end
      end
      // R3
      check(refs == MAXO, "R3 backlog cap", refs, MAXO);
      // R8
      check(spc_bad == 0, "R8 back-to-back spacing", spc_bad, 0);
      check(!rfsh_req, "R9 req after drain", rfsh_req, 0);
      @(negedge clk) rfsh_gnt = 0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule